// File: doc/BRIEF.md
# Random Bit Packer with Serial Sender

This block collects single bits from a source that runs on its own timing. The source signals each new bit with a ready level. The block puts eight such bits into a byte and then sends the byte to a host as one asynchronous serial frame. The ready level is not related to the block clock, so it passes through a chain of two flip-flops before any control logic sees it. A bit is taken only on a rising edge of that synchronized level, and the block returns an acknowledge so the source can clear its ready flag.

The block has two modes and runs one at a time. While it collects, the serial line stays idle high and a bit index picks the next byte position. Once the eighth bit is stored, the block changes to sending. During sending the index is held at zero and ready pulses are ignored. The byte goes out as one start bit, eight data bits least significant first and one stop bit, and each bit lasts a parameterized number of clocks. After the stop bit the block collects again from position zero.

Top module: `rand_bit_packer`

## Requirements
- R1: While the synchronous active-low reset is applied, and right after it, `ack_out` is 0 and `ser_tx` is 1. Any partial byte is discarded, so the next byte collected starts at bit position 0.
- R2: The ready input passes through two flip-flop stages. `ack_out` is still 0 after the second rising clock edge that follows a rise of `ready_async`, and it is 1 after the third.
- R3: The k-th bit accepted in a collecting phase (k = 0..7) is stored at byte position k. The transmitted byte therefore holds the first accepted bit in bit 0 and the eighth in bit 7.
- R4: Exactly one bit is accepted for each rising edge of the synchronized ready level, however long ready stays high.
- R5: `ack_out` goes to 1 when a bit is accepted. It returns to 0 on the third rising clock edge after `ready_async` falls, or earlier if the block enters sending mode.
- R6: Accepting the eighth bit switches the block to sending mode, and a start bit (0) appears on `ser_tx` within a few clocks.
- R7: `ser_tx` stays at 1 for the whole collecting phase.
- R8: A frame is one start bit (0), then data bits 0 to 7 in that order, then one stop bit (1). Each bit lasts `CLKS_PER_BIT` clocks.
- R9: In sending mode, ready pulses are ignored and the bit index is held at 0. The byte collected after the frame is built only from bits presented after the frame.
- R10: After the stop bit the block is back in collecting mode, with `ser_tx` at 1 and `ack_out` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_in | input | 1 | Bit value from the source, stable while ready is high |
| ready_async | input | 1 | Bit-ready level from the source, not synchronized to clk |
| ack_out | output | 1 | Acknowledge to the source |
| ser_tx | output | 1 | Serial transmit line, idle high |

## Verification
Some properties are checked on every cycle. The bit index is zero whenever the block is sending. The acknowledge falls one clock after the synchronized ready is seen low. Storing the last bit always switches the mode. The serial line is idle high throughout collecting, and a new frame never starts while one is in progress. Other behaviour can only be shown by the bench scenarios: bit order and frame timing on the line, the exact synchronizer latency, and single sampling of a long ready level. The same holds for ignoring ready pulses during a frame and for dropping a partial byte at reset.

// File: rtl/rbp_pkg.sv
// Shared types for the random bit packer.
// Assumes: one mode flag, two modes.
package rbp_pkg;
    typedef enum logic {
        MODE_COLLECT = 1'b0,
        MODE_SEND    = 1'b1
    } rbp_mode_e;
endpackage

// File: rtl/rbp_sync.sv
// Multi-stage synchronizer for one asynchronous level.
// Assumes: STAGES >= 2; the input may change at any time relative to clk.
module rbp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flip-flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];

    initial begin
        assert (STAGES >= 2) else $error("rbp_sync needs at least two stages");
    end
endmodule

// File: rtl/rbp_collector.sv
// Collects bits on rising edges of the synchronized ready level and owns the
// mode flag. Raises a one-cycle start pulse when the byte is complete.
// Assumes: bit_in is stable while the synchronized ready level is high.
module rbp_collector
    import rbp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_rdy,
    input  logic             bit_in,
    input  logic             tx_done,
    output logic             ack,
    output logic             start,
    output logic [WIDTH-1:0] byte_q,
    output rbp_mode_e        mode
);
    localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [IW-1:0] LAST = IW'(WIDTH - 1);

    logic [IW-1:0] idx;
    logic          rdy_prev;
    logic          rise;

    assign rise = sync_rdy && !rdy_prev;

    // Edge detection, bit storage, index, acknowledge and mode switching.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= MODE_COLLECT;
            idx      <= '0;
            byte_q   <= '0;
            ack      <= 1'b0;
            start    <= 1'b0;
            rdy_prev <= 1'b0;
        end else begin
            rdy_prev <= sync_rdy;
            start    <= 1'b0;
            if (mode == MODE_COLLECT) begin
                if (rise) begin
                    byte_q[idx] <= bit_in;
                    ack         <= 1'b1;
                    if (idx == LAST) begin
                        idx   <= '0;
                        mode  <= MODE_SEND;
                        start <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end else if (!sync_rdy) begin
                    ack <= 1'b0;
                end
            end else begin
                idx <= '0;
                ack <= 1'b0;
                if (tx_done) mode <= MODE_COLLECT;
            end
        end
    end

    assert_idx_zero_in_send_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SEND) |-> (idx == '0));

    assert_ack_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_rdy |=> !ack);

    assert_last_bit_switches_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_COLLECT && rise && idx == LAST) |=> (mode == MODE_SEND && start));
endmodule

// File: rtl/rbp_uart_tx.sv
// Serial frame sender: start bit, data LSB first, stop bit, fixed baud divider.
// Assumes: start is a single-cycle pulse that arrives only while idle.
module rbp_uart_tx #(
    parameter int WIDTH        = 8,
    parameter int CLKS_PER_BIT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] data,
    output logic             busy,
    output logic             done,
    output logic             tx
);
    localparam int FRAME = WIDTH + 2;
    localparam int CW    = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam int BW    = $clog2(FRAME);
    localparam logic [CW-1:0] CMAX = CW'(CLKS_PER_BIT - 1);
    localparam logic [BW-1:0] BMAX = BW'(FRAME - 1);

    logic [FRAME-1:0] shreg;
    logic [CW-1:0]    baud_cnt;
    logic [BW-1:0]    bit_cnt;

    // Load the frame, count baud periods and shift one bit per period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '1;
            baud_cnt <= '0;
            bit_cnt  <= '0;
            busy     <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    shreg    <= {1'b1, data, 1'b0};
                    baud_cnt <= '0;
                    bit_cnt  <= '0;
                    busy     <= 1'b1;
                end
            end else if (baud_cnt == CMAX) begin
                baud_cnt <= '0;
                if (bit_cnt == BMAX) begin
                    busy  <= 1'b0;
                    done  <= 1'b1;
                    shreg <= '1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                    shreg   <= {1'b1, shreg[FRAME-1:1]};
                end
            end else begin
                baud_cnt <= baud_cnt + 1'b1;
            end
        end
    end

    assign tx = shreg[0];

    assert_no_start_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    assert_start_bit_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !tx));
endmodule

// File: rtl/rand_bit_packer.sv
// Top level: synchronizes the asynchronous ready level, packs bits into a
// byte and sends each complete byte as one serial frame.
// Assumes: the source holds ready high until it sees the acknowledge.
module rand_bit_packer
    import rbp_pkg::*;
#(
    parameter int WIDTH        = 8,
    parameter int SYNC_STAGES  = 2,
    parameter int CLKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    input  logic ready_async,
    output logic ack_out,
    output logic ser_tx
);
    logic             sync_rdy;
    logic             start;
    logic             tx_busy;
    logic             tx_done;
    logic [WIDTH-1:0] byte_q;
    rbp_mode_e        mode;

    rbp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ready_async),
        .sync_out (sync_rdy)
    );

    rbp_collector #(.WIDTH(WIDTH)) u_collect (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_rdy (sync_rdy),
        .bit_in   (bit_in),
        .tx_done  (tx_done),
        .ack      (ack_out),
        .start    (start),
        .byte_q   (byte_q),
        .mode     (mode)
    );

    rbp_uart_tx #(.WIDTH(WIDTH), .CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .data  (byte_q),
        .busy  (tx_busy),
        .done  (tx_done),
        .tx    (ser_tx)
    );

    assert_idle_high_collect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_COLLECT) |-> (ser_tx && !tx_busy));

    assert_done_returns_collect_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> (mode == MODE_COLLECT && !ack_out));
endmodule

// File: tb/rand_bit_packer_bench.sv
module rand_bit_packer_bench;
    localparam int CPB = 8;
    localparam int NV  = 6;
    // [15:8] hold mask (bit held ready long), [7:0] byte
    localparam logic [15:0] VEC [0:NV-1] = '{
        16'h00_A5, 16'h00_3C, 16'h81_FF, 16'h10_00, 16'hFF_96, 16'h00_01
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_in = 1'b0;
    logic ready_async = 1'b0;
    logic ack_out, ser_tx;
    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    logic [7:0] rx_byte;

    always #5 clk = ~clk;

    rand_bit_packer #(.CLKS_PER_BIT(CPB)) u_rand_bit_packer (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .ready_async(ready_async),
        .ack_out(ack_out), .ser_tx(ser_tx)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present one bit with the ready/ack handshake; checks R2, R5, R7.
    task automatic send_bit(input logic b, input logic hold, input logic last);
        @(negedge clk);
        bit_in = b;
        ready_async = 1'b1;
        repeat (2) @(negedge clk);
        check("R2 ack not before third edge", {7'b0, ack_out}, 8'h0);
        @(negedge clk);
        check("R2 ack on third edge", {7'b0, ack_out}, 8'h1);
        if (!last) check("R7 line idle while collecting", {7'b0, ser_tx}, 8'h1);
        if (hold) repeat (20) @(negedge clk);
        ready_async = 1'b0;
        repeat (3) @(negedge clk);
        check("R5 ack low after ready falls", {7'b0, ack_out}, 8'h0);
    endtask

    task automatic send_byte(input logic [7:0] d, input logic [7:0] hold);
        for (int i = 0; i < 8; i++) send_bit(d[i], hold[i], i == 7);
    endtask

    // Receive one frame; checks R6, R8, R10.
    task automatic recv_frame(output logic [7:0] d);
        int t = 0;
        d = '0;
        @(negedge clk);
        while (ser_tx === 1'b1 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        check("R6 start bit appears", {7'b0, ser_tx}, 8'h0);
        repeat (CPB / 2) @(negedge clk);
        check("R8 start bit mid", {7'b0, ser_tx}, 8'h0);
        for (int i = 0; i < 8; i++) begin
            repeat (CPB) @(negedge clk);
            d[i] = ser_tx;
        end
        repeat (CPB) @(negedge clk);
        check("R8 stop bit", {7'b0, ser_tx}, 8'h1);
        repeat (CPB / 2 + 3) @(negedge clk);
        check("R10 line idle after frame", {7'b0, ser_tx}, 8'h1);
        check("R10 ack low after frame", {7'b0, ack_out}, 8'h0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                compared++;
                mismatched++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                summary();
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 ack low in reset", {7'b0, ack_out}, 8'h0);
        check("R1 line high in reset", {7'b0, ser_tx}, 8'h1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ack low after reset", {7'b0, ack_out}, 8'h0);
        check("R1 line high after reset", {7'b0, ser_tx}, 8'h1);

        // Vector table: bit order (R3), long ready levels (R4), framing (R8)
        for (int v = 0; v < NV; v++) begin
            fork
                send_byte(VEC[v][7:0], VEC[v][15:8]);
                recv_frame(rx_byte);
            join
            check("R3 R4 R8 byte received", rx_byte, VEC[v][7:0]);
        end

        // R9: ready pulses during a frame are ignored
        fork
            send_byte(8'hC3, 8'h00);
            recv_frame(rx_byte);
            begin
                wait (ser_tx === 1'b0);
                repeat (CPB * 2) @(negedge clk);
                bit_in = 1'b1;
                ready_async = 1'b1;
                repeat (6) @(negedge clk);
                ready_async = 1'b0;
                repeat (3) @(negedge clk);
                check("R9 no ack during send", {7'b0, ack_out}, 8'h0);
            end
        join
        check("R9 frame byte", rx_byte, 8'hC3);
        fork
            send_byte(8'h5A, 8'h00);
            recv_frame(rx_byte);
        join
        check("R9 next byte starts at bit 0", rx_byte, 8'h5A);

        // R1: reset in mid-collection discards the partial byte
        for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 ack low in mid reset", {7'b0, ack_out}, 8'h0);
        check("R1 line high in mid reset", {7'b0, ser_tx}, 8'h1);
        rst_n = 1'b1;
        fork
            send_byte(8'h24, 8'h00);
            recv_frame(rx_byte);
        join
        check("R1 byte after mid reset", rx_byte, 8'h24);

        summary();
    end
endmodule